// File: doc/BRIEF.md
# Match-Compare Timer with Sticky Status

This block is a free-running up-counter that runs on a slow timer clock of its own. Software reaches it over a simple word-addressed register port clocked by a much faster bus clock. Four compare channels watch the running count. When a channel's compare value equals a value the count takes, and that channel is enabled, the channel raises a sticky status bit. The status bit drives that channel's interrupt line until software clears it by writing a one.

A count write crosses into the timer clock domain through a toggle handshake. It therefore lands a few timer cycles after the bus write. While the write is in flight, a busy flag reads as one and count reads still return the old value. Count reads come from a snapshot register in the bus domain. The timer side publishes each new count with a toggle, and the snapshot captures it while it is stable, so a read never returns a half-updated value. Compare matching runs on these snapshots, which means a value loaded by software is compared like any other value. The bus clock must run at least four times faster than the timer clock.

Top module: `matchTimer`

## Requirements
- R1: The count is 32 bits wide. It increases by exactly one on every rising edge of the timer clock. After 0xFFFF_FFFF the next value is 0, and no other indication is given.
- R2: While reset is asserted, the following all read as zero: the count (word address 0), the status (address 1), the enable mask (address 2), the busy flag (address 3) and all four compares (addresses 4 to 7). All interrupt outputs are also low during reset.
- R3: A write to address 0 sets the busy flag (bit 0 of address 3), and the flag is seen on the next read. While the flag is set, reads of address 0 return the old running count. The flag clears in the same bus cycle that the written value first appears at address 0.
- R4: A write to address 0 is dropped while the busy flag is set. The pending value is still the one that gets applied.
- R5: Status bit i (bit i of address 1) sets when the count takes a value equal to compare i (address 4+i) while enable bit i (bit i of address 2) is one. This includes a match just after a wrap. When the enable bit is zero, the status bit does not set, and it does not set if the count never reaches the compare value.
- R6: A status bit stays set until a write to address 1 carries a one in that bit position. A zero in a bit position leaves that bit unchanged.
- R7: If a match and a clear reach the same status bit in the same bus cycle, the bit ends up set.
- R8: Interrupt output i always equals status bit i.
- R9: Compare registers read back exactly the 32-bit value written to them. The enable mask keeps only bits 3:0 of the written data. Unused upper bits of the status, enable and busy words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register port clock |
| tmrClk | input | 1 | Slow timer clock that advances the count |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| wrEn | input | 1 | Write strobe for the word at addr |
| addr | input | 3 | Word address: 0 count, 1 status, 2 enable, 3 busy, 4 to 7 compares |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the word at addr (combinational) |
| irq | output | 4 | Per-channel interrupt, equal to the status bits |

## Verification
A table of load values and compare settings is run on one channel. Each row tells apart one of these cases:
- a compare ahead of the count;
- a compare beyond the waiting window;
- a compare behind the count;
- a disabled channel;
- a match near the top of the range;
- a match just past the wrap.

Directed sequences cover the late landing of a count write. They show that reads return the old value during the busy window and the exact new value right after it. They also check that a second write during the busy window is dropped, and that the count advances by an exact number of steps over a fixed number of timer periods. A continuous stream of clear writes across a match shows whether set takes priority over clear. Zero writes and writes to other bit positions show that a set status bit keeps its state.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Word map of the register port; compares sit at 4..7 and are indexed by the low bits.
  localparam int ADDR_W = 3;
  localparam logic [1:0] W_COUNT  = 2'd0;
  localparam logic [1:0] W_STATUS = 2'd1;
  localparam logic [1:0] W_ENABLE = 2'd2;
  localparam logic [1:0] W_BUSY   = 2'd3;

  typedef struct packed {
    logic cntWr;   // accepted count write (not issued while busy)
    logic stsClr;  // write-one-to-clear of status
    logic enWr;    // enable mask write
    logic cmpWr;   // compare write, channel from addr low bits
  } mtStrobe_t;
endpackage

// File: rtl/mtCtrl.sv
module mtCtrl
  import mt_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output mtStrobe_t         strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (addr[ADDR_W-1]) begin
        strobe.cmpWr = 1'b1;
      end else begin
        case (addr[1:0])
          W_COUNT:  strobe.cntWr  = !busy;
          W_STATUS: strobe.stsClr = 1'b1;
          W_ENABLE: strobe.enWr   = 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mtTmrCount.sv
module mtTmrCount #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tmrClk,
  input  logic             rstN,
  input  logic             loadTgl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] tmrCnt,
  output logic             stepTgl,
  output logic             ackTgl
);
  logic [SYNC_STAGES-1:0] reqSync;
  logic                   reqSeen;
  logic                   loadNow;

  assign loadNow = reqSync[SYNC_STAGES-1] ^ reqSeen;
  assign ackTgl  = reqSeen;

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      reqSeen <= 1'b0;
      tmrCnt  <= '0;
      stepTgl <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-2:0], loadTgl};
      reqSeen <= reqSync[SYNC_STAGES-1];
      tmrCnt  <= loadNow ? loadVal : tmrCnt + CNT_W'(1);
      stepTgl <= ~stepTgl;
    end
  end
endmodule

// File: rtl/mtData.sv
module mtData
  import mt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  mtStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  tmrCnt,
  input  logic              stepTgl,
  input  logic              ackTgl,
  output logic              loadTgl,
  output logic [CNT_W-1:0]  loadVal,
  output logic              busy,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [SYNC_STAGES-1:0] stepSync, ackSync;
  logic                   stepSeen, ackApplied, upd;
  logic [CNT_W-1:0]       busCnt;
  logic [CNT_W-1:0]       cmp [NUM_CH];
  logic [NUM_CH-1:0]      en, sts, stsNext, hit, clrMask;

  assign upd  = stepSync[SYNC_STAGES-1] ^ stepSeen;
  assign busy = loadTgl ^ ackApplied;
  assign irq  = sts;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_match
    assign hit[i] = upd && en[i] && (tmrCnt == cmp[i]);
  end

  assign clrMask = strobe.stsClr ? wrData[NUM_CH-1:0] : '0;
  assign stsNext = (sts & ~clrMask) | hit;  // a new match outranks the clear

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      stepSync   <= '0;
      ackSync    <= '0;
      stepSeen   <= 1'b0;
      ackApplied <= 1'b0;
      busCnt     <= '0;
      loadTgl    <= 1'b0;
      loadVal    <= '0;
      en         <= '0;
      sts        <= '0;
      for (int i = 0; i < NUM_CH; i++) cmp[i] <= '0;
    end else begin
      stepSync <= {stepSync[SYNC_STAGES-2:0], stepTgl};
      ackSync  <= {ackSync[SYNC_STAGES-2:0], ackTgl};
      stepSeen <= stepSync[SYNC_STAGES-1];
      if (upd) begin
        busCnt     <= tmrCnt;
        ackApplied <= ackSync[SYNC_STAGES-1];
      end
      if (strobe.cntWr) begin
        loadTgl <= ~loadTgl;
        loadVal <= wrData;
      end
      if (strobe.enWr) en <= wrData[NUM_CH-1:0];
      if (strobe.cmpWr) cmp[addr[IDX_W-1:0]] <= wrData;
      sts <= stsNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr[ADDR_W-1]) begin
      rdData = cmp[addr[IDX_W-1:0]];
    end else begin
      case (addr[1:0])
        W_COUNT:  rdData = busCnt;
        W_STATUS: rdData[NUM_CH-1:0] = sts;
        W_ENABLE: rdData[NUM_CH-1:0] = en;
        default:  rdData[0] = busy;
      endcase
    end
  end
endmodule

// File: rtl/matchTimer.sv
module matchTimer
  import mt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              tmrClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);
  mtStrobe_t        strobe;
  logic             busy, loadTgl, stepTgl, ackTgl;
  logic [CNT_W-1:0] loadVal, tmrCnt;

  mtCtrl ctrl_i (.wrEn(wrEn), .addr(addr), .busy(busy), .strobe(strobe));

  mtData #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) data_i (
    .busClk(busClk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .tmrCnt(tmrCnt), .stepTgl(stepTgl), .ackTgl(ackTgl), .loadTgl(loadTgl),
    .loadVal(loadVal), .busy(busy), .rdData(rdData), .irq(irq)
  );

  mtTmrCount #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) tmr_i (
    .tmrClk(tmrClk), .rstN(rstN), .loadTgl(loadTgl), .loadVal(loadVal),
    .tmrCnt(tmrCnt), .stepTgl(stepTgl), .ackTgl(ackTgl)
  );
endmodule

// File: rtl/mtChecker.sv
module mtChecker
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4
) (
  input logic              busClk,
  input logic              tmrClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] wrBits,
  input logic [NUM_CH-1:0] irq,
  input mtStrobe_t         strobe,
  input logic              busy,
  input logic [CNT_W-1:0]  loadVal,
  input logic [CNT_W-1:0]  tmrCnt,
  input logic              ackTgl
);
  logic [NUM_CH-1:0] clrReq;
  assign clrReq = (wrEn && addr == {1'b0, W_STATUS}) ? wrBits : '0;

  // R3: an accepted count write leaves the block busy in the next cycle
  p_busy_after_write_r3: assert property (@(posedge busClk) disable iff (!rstN)
    strobe.cntWr |=> busy);

  // R4: the pending load value does not move while a write is in flight
  p_hold_while_busy_r4: assert property (@(posedge busClk) disable iff (!rstN)
    busy |=> $stable(loadVal));

  // R6: a set status bit only drops where a one was written to clear it
  p_sticky_status_r6: assert property (@(posedge busClk) disable iff (!rstN)
    (irq != '0) |=> ((($past(irq) & ~$past(clrReq)) & ~irq) == '0));

  // R1: between loads the count advances by exactly one per timer edge
  p_count_step_r1: assert property (@(posedge tmrClk) disable iff (!rstN)
    rstN |=> (!$stable(ackTgl) || tmrCnt == $past(tmrCnt) + CNT_W'(1)));
endmodule

bind matchTimer mtChecker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .busClk(busClk), .tmrClk(tmrClk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .wrBits(wrData[NUM_CH-1:0]), .irq(irq), .strobe(strobe), .busy(busy),
  .loadVal(loadVal), .tmrCnt(tmrCnt), .ackTgl(ackTgl)
);

// File: tb/matchTimer_tb.sv
module matchTimer_tb_top;
  localparam int TMR_PERIOD = 40;

  logic        busClk = 1'b0;
  logic        tmrClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        wrEn   = 1'b0;
  logic [2:0]  addr   = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  matchTimer dut_i (.busClk(busClk), .tmrClk(tmrClk), .rstN(rstN), .wrEn(wrEn),
                    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq));

  always #2 busClk = ~busClk;  // 250 MHz
  initial begin
    #11;
    forever begin tmrClk = 1'b1; #(TMR_PERIOD/2); tmrClk = 1'b0; #(TMR_PERIOD/2); end
  end

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] cmpVal;
    logic        enable;
    logic        expSet;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'd10,         32'd15,         1'b1, 1'b1},
    '{32'd10,         32'd30,         1'b1, 1'b0},
    '{32'd100,        32'd99,         1'b1, 1'b0},
    '{32'd10,         32'd15,         1'b0, 1'b0},
    '{32'hFFFF_FFF0,  32'hFFFF_FFF8,  1'b1, 1'b1},
    '{32'hFFFF_FFFA,  32'd2,          1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge busClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge busClk);
    wrEn = 1'b0; addr = a;
    #1 v = rdData;
  endtask

  task automatic waitIdle();
    logic [31:0] b;
    b = 32'd1;
    for (int n = 0; n < 300 && b[0]; n++) rd(3'd3, b);
    check("R3 busy clears", b, 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        seen;

    // R2: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R2 reset register", v, 32'd0);
    end
    check("R2 reset irq", {28'd0, irq}, 32'd0);
    @(negedge busClk); #1 rstN = 1'b1;

    // R9: register readback and unused bits
    wr(3'd4, 32'hDEAD_BEEF); rd(3'd4, v); check("R9 compare0", v, 32'hDEAD_BEEF);
    wr(3'd6, 32'h1234_5678); rd(3'd6, v); check("R9 compare2", v, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R9 enable width", v, 32'h0000_000F);
    wr(3'd2, 32'h0);
    rd(3'd1, v); check("R9 status upper bits", v, 32'd0);

    // R3 and R1: late landing, then exact stepping
    wr(3'd0, 32'd1000);
    rd(3'd3, v); check("R3 busy after write", v, 32'd1);
    rd(3'd0, v); check("R3 old value while busy", {31'd0, v == 32'd1000}, 32'd0);
    waitIdle();
    rd(3'd0, v); check("R3 new value after busy", v, 32'd1000);
    #(5*TMR_PERIOD);
    rd(3'd0, v); check("R1 five steps", v, 32'd1005);

    // R1: wrap to zero
    wr(3'd0, 32'hFFFF_FFFE);
    waitIdle();
    rd(3'd0, v); check("R1 before wrap", v, 32'hFFFF_FFFE);
    #(2*TMR_PERIOD);
    rd(3'd0, v); check("R1 wrap to zero", v, 32'd0);

    // R4: second write during busy dropped
    wr(3'd0, 32'd5000);
    wr(3'd0, 32'd7000);
    waitIdle();
    rd(3'd0, v); check("R4 dropped write", v, 32'd5000);

    // R5 and R8: vector table on channel 3
    foreach (VECS[k]) begin
      wr(3'd2, {28'd0, VECS[k].enable, 3'd0});
      wr(3'd7, VECS[k].cmpVal);
      wr(3'd0, VECS[k].start);
      waitIdle();
      wr(3'd1, 32'hF);
      #(10*TMR_PERIOD);
      rd(3'd1, v);
      check($sformatf("R5 vector %0d status", k), {31'd0, v[3]}, {31'd0, VECS[k].expSet});
      check($sformatf("R8 vector %0d irq", k), {31'd0, irq[3]}, {31'd0, VECS[k].expSet});
    end

    // R6: sticky status and write-one-to-clear on channel 0
    wr(3'd2, 32'h1);
    wr(3'd4, 32'd300);
    wr(3'd0, 32'd290);
    waitIdle();
    wr(3'd1, 32'hF);
    #(15*TMR_PERIOD);
    rd(3'd1, v); check("R5 channel0 set", v, 32'h1);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R6 zero write no effect", v, 32'h1);
    wr(3'd1, 32'h2);
    rd(3'd1, v); check("R6 other bit no effect", v, 32'h1);
    check("R8 irq follows status", {28'd0, irq}, 32'h1);
    wr(3'd1, 32'h1);
    rd(3'd1, v); check("R6 cleared by one", v, 32'h0);
    check("R8 irq low after clear", {28'd0, irq}, 32'h0);

    // R7: continuous clears across a match; set must show for a cycle
    wr(3'd4, 32'd400);
    wr(3'd0, 32'd390);
    waitIdle();
    wr(3'd1, 32'hF);
    seen = 1'b0;
    for (int n = 0; n < 15*TMR_PERIOD/4; n++) begin
      @(negedge busClk);
      wrEn = 1'b1; addr = 3'd1; wrData = 32'h1;
      #1 if (rdData[0] && irq[0]) seen = 1'b1;
    end
    @(negedge busClk); wrEn = 1'b0;
    check("R7 set wins over clear", {31'd0, seen}, 32'd1);
    rd(3'd1, v); check("R7 cleared afterwards", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule